// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a four-beat burst. On an enabled clock edge a control input either captures a fresh external address, which becomes the first beat, or steps an internal beat index so that the next address of the burst appears. The two least significant address bits follow one of two orderings chosen by a static mode input. In the linear ordering they count upward and wrap, and in the interleaved ordering they are the starting offset XORed with the beat index. The bits above those two never move during advances, so every burst stays inside its aligned four-word block.

An active-low clock-enable input freezes the whole block. While it is high, the load/advance control, the external address and the captured state are all ignored, and the output address holds. The output is formed combinationally from the stored base and beat index. It therefore changes just after the enabled edge that loads or advances. The mode input is applied to that stored state, and continued advancing past the fourth beat repeats the same four addresses.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted and until the first enabled load or advance, `addr_o` is all zeros.
- R2: On a rising clock edge with `clk_en_n` = 0 and `adv_ld` = 0, `addr_o` becomes `ext_addr` after the edge, and that address is beat 0 of a new burst.
- R3: With `order_sel` = 0 (linear), each enabled edge with `adv_ld` = 1 sets the two low bits of `addr_o` to their previous value plus one, modulo 4. For example, a start offset of 1 gives 1, 2, 3, 0.
- R4: With `order_sel` = 1 (interleaved), the two low bits on beat k (k = 0..3) equal the start offset XOR k. For example, a start offset of 1 gives 1, 0, 3, 2.
- R5: An enabled advance never changes `addr_o` bits above bit 1.
- R6: After four enabled advances from a load, `addr_o` equals the loaded address again, and further advances repeat the same four-address sequence.
- R7: While `clk_en_n` = 1, clock edges change nothing: `addr_o` holds, and a load request or a new `ext_addr` presented during those edges is ignored.
- R8: An enabled load in the middle of a burst discards the remaining beats and restarts at beat 0 from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| adv_ld | input | 1 | 0 = load `ext_addr`, 1 = advance to the next beat |
| order_sel | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W (19) | External starting address, captured on a load |
| addr_o | output | ADDR_W (19) | Current burst address |

## Verification
The checker treats `order_sel` as static. The linear step property excuses any cycle in which the mode is 1. The beat-position and wrap properties tolerate a change of mode between bursts, because they test the offset against the recorded start offset under whichever ordering is selected. All properties are disabled until the internal synchronized reset releases, so commands issued during the two release cycles are outside their scope. The bench drives `clk_en_n` high until that window has passed, and it changes `order_sel` only between bursts, just before a load.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Ordering of the low offset bits inside one burst block.
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  // Command decoded from the load/advance control.
  typedef enum logic {
    CMD_LOAD    = 1'b0,
    CMD_ADVANCE = 1'b1
  } burst_cmd_e;

endpackage

// File: rtl/burst_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/burst_base_reg.sv
// Holds the address captured at the start of a burst.
module burst_base_reg #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] base_q
);

  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) begin
      base_d = load_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat index inside the burst; clears on load, wraps on advance.
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             load_en,
  input  logic             adv_en,
  output logic [OFS_W-1:0] beat_q
);

  logic [OFS_W-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    if (load_en) begin
      beat_d = '0;
    end else if (adv_en) begin
      beat_d = beat_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/burst_offset_map.sv
// Maps start offset and beat index to the current low address bits.
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  burst_order_e     order,
  input  logic [OFS_W-1:0] start_ofs,
  input  logic [OFS_W-1:0] beat,
  output logic [OFS_W-1:0] ofs
);

  logic [OFS_W-1:0] ofs_lin;
  logic [OFS_W-1:0] ofs_xor;

  // Linear: ripple sum of start and beat, carry out dropped (wrap).
  logic [OFS_W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar b = 0; b < OFS_W; b++) begin : g_bit
    assign ofs_lin[b]   = start_ofs[b] ^ beat[b] ^ carry[b];
    assign carry[b+1]   = (start_ofs[b] & beat[b]) |
                          (carry[b] & (start_ofs[b] ^ beat[b]));
    assign ofs_xor[b]   = start_ofs[b] ^ beat[b];
  end

  always_comb begin
    unique case (order)
      ORD_XOR:    ofs = ofs_xor;
      default:    ofs = ofs_lin;
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              adv_ld,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int OFS_W = $clog2(BURST_LEN);

  logic              rst_q_n;
  logic              active;
  burst_cmd_e        cmd;
  logic              load_en;
  logic              adv_en;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  beat_q;
  logic [OFS_W-1:0]  ofs;
  burst_order_e      order;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Command decode, qualified by the active-low clock enable.
  assign active  = ~clk_en_n;
  assign cmd     = burst_cmd_e'(adv_ld);
  assign load_en = active & (cmd == CMD_LOAD);
  assign adv_en  = active & (cmd == CMD_ADVANCE);
  assign order   = burst_order_e'(order_sel);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .load_en   (load_en),
    .load_addr (ext_addr),
    .base_q    (base_q)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .load_en (load_en),
    .adv_en  (adv_en),
    .beat_q  (beat_q)
  );

  burst_offset_map #(.OFS_W(OFS_W)) u_map (
    .order     (order),
    .start_ofs (base_q[OFS_W-1:0]),
    .beat      (beat_q),
    .ofs       (ofs)
  );

  assign addr_o = {base_q[ADDR_W-1:OFS_W], ofs};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 19,
  parameter int OFS_W  = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              clk_en_n,
  input logic              adv_ld,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr_o
);

  // Independent record of the start offset and beats taken.
  logic [OFS_W-1:0] chk_start;
  logic [OFS_W-1:0] chk_beat;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chk_start <= '0;
      chk_beat  <= '0;
    end else if (!clk_en_n) begin
      if (!adv_ld) begin
        chk_start <= ext_addr[OFS_W-1:0];
        chk_beat  <= '0;
      end else begin
        chk_beat  <= chk_beat + OFS_W'(1);
      end
    end
  end

  // R1: zero out of reset before any command
  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rst_q_n) |-> (addr_o == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && !adv_ld) |=> (addr_o == $past(ext_addr)));

  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && adv_ld && !order_sel) |=>
      (order_sel || addr_o[OFS_W-1:0] == $past(addr_o[OFS_W-1:0]) + OFS_W'(1)));

  p_beat_pos_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    addr_o[OFS_W-1:0] == (order_sel ? (chk_start ^ chk_beat)
                                    : (chk_start + chk_beat)));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && adv_ld) |=>
      (addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W])));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!clk_en_n && adv_ld && chk_beat == {OFS_W{1'b1}}) |=>
      (addr_o[OFS_W-1:0] == chk_start));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    clk_en_n |=> $stable(addr_o));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .clk_en_n  (clk_en_n),
  .adv_ld    (adv_ld),
  .order_sel (order_sel),
  .ext_addr  (ext_addr),
  .addr_o    (addr_o)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;

  localparam int AW = 19;

  logic          clk;
  logic          rst_n;
  logic          clk_en_n;
  logic          adv_ld;
  logic          order_sel;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] addr_o;

  int checks;
  int errors;
  bit done;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .adv_ld    (adv_ld),
    .order_sel (order_sel),
    .ext_addr  (ext_addr),
    .addr_o    (addr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL %s: addr_o=%h expected=%h at %0t", req, addr_o, exp, $time);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the following rising edge.
  task automatic step(input logic en_n, input logic adv, input logic [AW-1:0] a);
    @(negedge clk);
    clk_en_n = en_n;
    adv_ld   = adv;
    ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] exp_ofs(input logic mode, input logic [1:0] s,
                                         input logic [1:0] k);
    return mode ? (s ^ k) : (s + k);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; clk_en_n = 1'b1; adv_ld = 1'b1; order_sel = 1'b0;
    ext_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b0, 19'h5A5A5);
    check("R1 after release", '0);
  endtask

  // Load, then four advances (wrap) and two more (repeat).
  task automatic t_burst(input logic mode, input logic [1:0] s,
                         input logic [AW-3:0] hi);
    logic [AW-1:0] a;
    a = {hi, s};
    @(negedge clk);
    order_sel = mode;
    step(1'b0, 1'b0, a);
    check("R2 load", a);
    for (int k = 1; k <= 6; k++) begin
      step(1'b0, 1'b1, ~a);
      if (k == 4)
        check("R6 wrap to start", a);
      else if (mode)
        check("R4 interleaved beat R5", {hi, exp_ofs(1'b1, s, 2'(k))});
      else
        check("R3 linear beat R5", {hi, exp_ofs(1'b0, s, 2'(k))});
    end
  endtask

  // Stall mid burst, presenting a load that must be ignored.
  task automatic t_stall(input logic mode, input logic [1:0] s);
    logic [AW-1:0] a;
    a = {17'h1ABCD, s};
    @(negedge clk);
    order_sel = mode;
    step(1'b0, 1'b0, a);
    step(1'b0, 1'b1, '0);
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, 19'h7FFFF);
      check("R7 hold while disabled", {a[AW-1:2], exp_ofs(mode, s, 2'd1)});
    end
    step(1'b1, 1'b1, '0);
    check("R7 hold on advance", {a[AW-1:2], exp_ofs(mode, s, 2'd1)});
    step(1'b0, 1'b1, '0);
    check("R7 resume after stall", {a[AW-1:2], exp_ofs(mode, s, 2'd2)});
  endtask

  task automatic t_reload();
    @(negedge clk);
    order_sel = 1'b0;
    step(1'b0, 1'b0, 19'h00012);
    step(1'b0, 1'b1, '0);
    check("R8 pre reload", 19'h00013);
    step(1'b0, 1'b0, 19'h4000F);
    check("R8 reload mid burst", 19'h4000F);
    step(1'b0, 1'b1, '0);
    check("R8 restart beat", 19'h4000C);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    t_reset();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        t_burst(1'(m), 2'(s), 17'(17'h0ACE1 + s * 17'h1111 + m));
      end
    end
    t_burst(1'b1, 2'd3, '1);
    t_burst(1'b0, 2'd3, '1);
    t_stall(1'b0, 2'd2);
    t_stall(1'b1, 2'd1);
    t_reload();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule